// File: doc/BRIEF.md
# Uncached Block-Memory Manager

This block is the manager end of a five-channel coherent bus that serves only the built-in uncached request types. It owns a small block-organised memory, with each block made of several beats. It accepts requests on a valid/ready acquire channel. Depending on the request, it reads one beat or a whole block, writes bytes under a mask, runs a sub-word atomic read-modify-write, or acknowledges a prefetch. It answers every request with a grant on a valid/ready grant channel.

Each grant echoes the client's transaction id and carries the manager's own id. The manager keeps one transaction in flight. After the last grant beat, the transaction stays open until the client returns a finish message carrying that manager id. No new request is accepted while a transaction is open, so no second transaction can touch the same block before the client has confirmed receipt.

Top module: `ucbus_mem_manager`

## Requirements
- R1: After reset `acq_ready` is 1, `gnt_valid` is 0, `fin_ready` is 0, and every memory beat reads as zero.
- R2: Request codes on `acq_kind` are 000 single-beat get, 001 block get, 010 single-beat put, 011 block put, 100 atomic, 101 prefetch. The grant code on `gnt_kind` is 100 for a single-beat get and for an atomic, 101 for a block get, 011 for either put, and 001 for a prefetch. Every grant carries the request's `acq_cxid` on `gnt_cxid` and manager id 0 on `gnt_mxid`.
- R3: A single-beat get returns the beat at (`acq_block`, `acq_beat`), with `gnt_beat` equal to `acq_beat`.
- R4: A block get returns all 4 beats of the block, one grant beat per handshake, with `gnt_beat` ascending 0, 1, 2, 3.
- R5: A put writes only the bytes whose mask bit is set; mask bit i covers data bits 8i+7..8i. A block put takes 4 beats written to beats 0..3 in order, ignores `acq_beat`, and raises its put ack only after the fourth beat is accepted.
- R6: An atomic acts on an operand of 2^`acq_amo_size` bytes (0 byte, 1 half, 2 word, 3 double). The operand lane starts at `acq_amo_byte` rounded down to operand alignment. The source operand comes from the same lane of `acq_data`. Opcodes are 0 swap, 1 add, 2 xor, 3 and, 4 signed min, 5 signed max, 6 unsigned min, 7 unsigned max. Bytes outside the lane are unchanged.
- R7: An atomic's grant carries the whole beat's value from before the update. Min and max compare on the operand width, and the signed forms sign-extend from the operand's top bit.
- R8: Once a request is accepted, `acq_ready` stays low until every grant beat has been taken and a finish with id 0 has been accepted. `fin_ready` is high only while that finish is awaited, and `gnt_valid` and `acq_ready` are never high together.
- R9: A finish whose `fin_mxid` is not 0 is consumed but leaves the transaction open.
- R10: While `gnt_valid` is high and `gnt_ready` is low, all grant fields hold their values.
- R11: A prefetch leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_valid | input | 1 | Request beat valid |
| acq_ready | output | 1 | Request beat accepted |
| acq_kind | input | 3 | Request code |
| acq_cxid | input | CXID_W | Client transaction id |
| acq_block | input | log2(BLOCKS) | Block address |
| acq_beat | input | log2(BEATS) | Beat index within block |
| acq_data | input | DATA_W | Write data or atomic source operand |
| acq_mask | input | DATA_W/8 | Per-byte write enables for puts |
| acq_amo_op | input | 3 | Atomic opcode |
| acq_amo_size | input | 2 | Atomic operand size code |
| acq_amo_byte | input | log2(DATA_W/8) | Atomic byte offset within the beat |
| gnt_valid | output | 1 | Grant beat valid |
| gnt_ready | input | 1 | Grant beat taken |
| gnt_kind | output | 3 | Grant code |
| gnt_cxid | output | CXID_W | Echoed client transaction id |
| gnt_mxid | output | MXID_W | Manager transaction id |
| gnt_beat | output | log2(BEATS) | Beat index of returned data |
| gnt_data | output | DATA_W | Returned data, zero for acknowledgements |
| fin_valid | input | 1 | Finish message valid |
| fin_ready | output | 1 | Finish message accepted |
| fin_mxid | input | MXID_W | Manager id being finished |

## Verification
A request accepted at clock edge k raises its first grant beat from edge k on. Each grant handshake at edge g moves to the next beat, or to the wait for the finish, from edge g on. A block put's ack appears only after the edge that accepts its fourth beat. A good finish at edge f reopens `acq_ready` from edge f. The bench's reference model advances on the same edges from the handshakes it drives. It is compared against the ports in the middle of every cycle, so each result is checked in exactly the cycle it falls due and in every cycle it is held.

// File: rtl/ucbus_mem_manager.sv
module ucbus_mem_manager #(
  parameter int BEATS  = 4,
  parameter int DATA_W = 64,
  parameter int BLOCKS = 16,
  parameter int CXID_W = 4,
  parameter int MXID_W = 1,
  parameter logic [MXID_W-1:0] MY_MXID = '0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  acq_valid,
  output logic                                  acq_ready,
  input  logic [2:0]                            acq_kind,
  input  logic [CXID_W-1:0]                     acq_cxid,
  input  logic [((BLOCKS>1)?$clog2(BLOCKS):1)-1:0] acq_block,
  input  logic [((BEATS>1)?$clog2(BEATS):1)-1:0]   acq_beat,
  input  logic [DATA_W-1:0]                     acq_data,
  input  logic [DATA_W/8-1:0]                   acq_mask,
  input  logic [2:0]                            acq_amo_op,
  input  logic [1:0]                            acq_amo_size,
  input  logic [$clog2(DATA_W/8)-1:0]           acq_amo_byte,
  output logic                                  gnt_valid,
  input  logic                                  gnt_ready,
  output logic [2:0]                            gnt_kind,
  output logic [CXID_W-1:0]                     gnt_cxid,
  output logic [MXID_W-1:0]                     gnt_mxid,
  output logic [((BEATS>1)?$clog2(BEATS):1)-1:0]   gnt_beat,
  output logic [DATA_W-1:0]                     gnt_data,
  input  logic                                  fin_valid,
  output logic                                  fin_ready,
  input  logic [MXID_W-1:0]                     fin_mxid
);
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int BLK_W  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
  localparam int MASK_W = DATA_W / 8;
  localparam int BYTE_W = $clog2(MASK_W);
  localparam int DEPTH  = BLOCKS * BEATS;
  localparam int IDX_W  = BLK_W + BEAT_W;
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  localparam logic [2:0] A_GET = 3'b000, A_GETBLK = 3'b001, A_PUT = 3'b010,
                         A_PUTBLK = 3'b011, A_AMO = 3'b100;
  localparam logic [2:0] G_PFACK = 3'b001, G_PUTACK = 3'b011,
                         G_BEAT = 3'b100, G_BLOCK = 3'b101;

  typedef enum logic [1:0] {S_IDLE, S_BPUT, S_GNT, S_FIN} st_t;

  st_t                st;
  logic [BLK_W-1:0]   blk_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [CXID_W-1:0]  cxid_q;
  logic [2:0]         gkind_q;
  logic [DATA_W-1:0]  old_q;
  logic [DATA_W-1:0]  mem [DEPTH];

  logic               acq_fire, gnt_fire, fin_fire;
  logic [IDX_W-1:0]   acq_idx, wr_idx;
  logic [DATA_W-1:0]  cur, amo_new, wr_data;
  logic [MASK_W-1:0]  wr_mask;
  logic               wr_en;

  function automatic logic [DATA_W-1:0] amo_apply(
    input logic [DATA_W-1:0] old, input logic [DATA_W-1:0] src,
    input logic [2:0] op, input logic [1:0] sz, input logic [BYTE_W-1:0] boff);
    int w, sh;
    logic [DATA_W-1:0] lane_m, a, b, sa, sb, r;
    w      = 8 << sz;
    sh     = int'((boff >> sz) << sz) * 8;
    lane_m = {DATA_W{1'b1}} >> (DATA_W - w);
    a      = (old >> sh) & lane_m;
    b      = (src >> sh) & lane_m;
    sa     = a[w-1] ? (a | ~lane_m) : a;
    sb     = b[w-1] ? (b | ~lane_m) : b;
    case (op)
      3'd0: r = b;
      3'd1: r = a + b;
      3'd2: r = a ^ b;
      3'd3: r = a & b;
      3'd4: r = ($signed(sa) < $signed(sb)) ? a : b;
      3'd5: r = ($signed(sa) > $signed(sb)) ? a : b;
      3'd6: r = (a < b) ? a : b;
      default: r = (a > b) ? a : b;
    endcase
    return (old & ~(lane_m << sh)) | ((r & lane_m) << sh);
  endfunction

  assign acq_ready = (st == S_IDLE) || (st == S_BPUT);
  assign gnt_valid = (st == S_GNT);
  assign fin_ready = (st == S_FIN);
  assign acq_fire  = acq_valid && acq_ready;
  assign gnt_fire  = gnt_valid && gnt_ready;
  assign fin_fire  = fin_valid && fin_ready;

  assign acq_idx = {acq_block, acq_beat};
  assign cur     = mem[acq_idx];
  assign amo_new = amo_apply(cur, acq_data, acq_amo_op, acq_amo_size, acq_amo_byte);

  assign gnt_kind = gkind_q;
  assign gnt_cxid = cxid_q;
  assign gnt_mxid = MY_MXID;
  assign gnt_beat = beat_q;
  assign gnt_data = (gkind_q == G_BEAT)  ? old_q :
                    (gkind_q == G_BLOCK) ? mem[{blk_q, beat_q}] : '0;

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = acq_idx;
    wr_data = acq_data;
    wr_mask = acq_mask;
    if (acq_fire) begin
      if (st == S_BPUT) begin
        wr_en  = 1'b1;
        wr_idx = {blk_q, beat_q};
      end else begin
        case (acq_kind)
          A_PUT:    wr_en = 1'b1;
          A_PUTBLK: begin
            wr_en  = 1'b1;
            wr_idx = {acq_block, {BEAT_W{1'b0}}};
          end
          A_AMO: begin
            wr_en   = 1'b1;
            wr_data = amo_new;
            wr_mask = '1;
          end
          default: wr_en = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < MASK_W; b++)
        if (wr_mask[b]) mem[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      blk_q   <= '0;
      beat_q  <= '0;
      cxid_q  <= '0;
      gkind_q <= G_PFACK;
      old_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (acq_fire) begin
          cxid_q <= acq_cxid;
          blk_q  <= acq_block;
          beat_q <= acq_beat;
          st     <= S_GNT;
          case (acq_kind)
            A_GET: begin
              gkind_q <= G_BEAT;
              old_q   <= cur;
            end
            A_GETBLK: begin
              gkind_q <= G_BLOCK;
              beat_q  <= '0;
            end
            A_PUT: gkind_q <= G_PUTACK;
            A_PUTBLK: begin
              gkind_q <= G_PUTACK;
              beat_q  <= BEAT_W'(1);
              if (BEATS > 1) st <= S_BPUT;
            end
            A_AMO: begin
              gkind_q <= G_BEAT;
              old_q   <= cur;
            end
            default: gkind_q <= G_PFACK;
          endcase
        end
        S_BPUT: if (acq_fire) begin
          if (beat_q == LAST) st <= S_GNT;
          else beat_q <= beat_q + 1'b1;
        end
        S_GNT: if (gnt_fire) begin
          if (gkind_q == G_BLOCK && beat_q != LAST) beat_q <= beat_q + 1'b1;
          else st <= S_FIN;
        end
        default: if (fin_fire && fin_mxid == MY_MXID) st <= S_IDLE;
      endcase
    end
  end

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_kind) && $stable(gnt_beat)
                                && $stable(gnt_data) && $stable(gnt_cxid)); // R10
  AST_BLOCK_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_fire && gnt_kind == G_BLOCK && gnt_beat != LAST
      |=> gnt_valid && gnt_kind == G_BLOCK && gnt_beat == BEAT_W'($past(gnt_beat) + 1'b1)); // R4
  AST_WAIT_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_fire && gnt_kind != G_BLOCK |=> !acq_ready && fin_ready); // R8
  AST_FIN_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    fin_fire && fin_mxid == MY_MXID |=> acq_ready && !gnt_valid); // R8
  AST_BAD_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    fin_fire && fin_mxid != MY_MXID |=> !acq_ready && fin_ready); // R9
  AST_CHAN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_valid && acq_ready)); // R8
endmodule

// File: tb/tb_ucbus_mem_manager.sv
`timescale 1ns/1ps
module tb_ucbus_mem_manager;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        acq_valid = 1'b0, acq_ready;
  logic [2:0]  acq_kind = '0;
  logic [3:0]  acq_cxid = '0, acq_block = '0;
  logic [1:0]  acq_beat = '0;
  logic [63:0] acq_data = '0;
  logic [7:0]  acq_mask = '0;
  logic [2:0]  acq_amo_op = '0;
  logic [1:0]  acq_amo_size = '0;
  logic [2:0]  acq_amo_byte = '0;
  logic        gnt_valid, gnt_ready = 1'b1;
  logic [2:0]  gnt_kind;
  logic [3:0]  gnt_cxid;
  logic [0:0]  gnt_mxid;
  logic [1:0]  gnt_beat;
  logic [63:0] gnt_data;
  logic        fin_valid = 1'b0, fin_ready;
  logic [0:0]  fin_mxid = '0;

  ucbus_mem_manager dut (.*);

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit bp = 0;
  string cur_tag = "R3";
  logic [63:0] bp_data [4];
  logic [7:0]  bp_mask [4];

  // reference model
  logic [63:0] rmem [64];
  int mph = 0, bcnt = 0;
  logic [3:0] bblk;
  logic [2:0]  q_kind [$];
  logic [3:0]  q_cx [$];
  logic [1:0]  q_beat [$];
  logic [63:0] q_data [$];
  bit          q_hd [$];
  string       q_tag [$];
  bit prev_stall = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [63:0] ref_amo(logic [63:0] old, logic [63:0] src,
                                         logic [2:0] op, logic [1:0] sz, logic [2:0] bo);
    int lo;
    longint sa, sb;
    longint unsigned ua, ub, r;
    logic [63:0] res;
    lo = (int'(bo) / (1 << sz)) * (1 << sz) * 8;
    case (sz)
      2'd0: begin ua = old[lo +: 8];  ub = src[lo +: 8];
                  sa = $signed(old[lo +: 8]);  sb = $signed(src[lo +: 8]); end
      2'd1: begin ua = old[lo +: 16]; ub = src[lo +: 16];
                  sa = $signed(old[lo +: 16]); sb = $signed(src[lo +: 16]); end
      2'd2: begin ua = old[lo +: 32]; ub = src[lo +: 32];
                  sa = $signed(old[lo +: 32]); sb = $signed(src[lo +: 32]); end
      default: begin ua = old; ub = src; sa = $signed(old); sb = $signed(src); end
    endcase
    case (op)
      3'd0: r = ub;
      3'd1: r = ua + ub;
      3'd2: r = ua ^ ub;
      3'd3: r = ua & ub;
      3'd4: r = (sa < sb) ? ua : ub;
      3'd5: r = (sa > sb) ? ua : ub;
      3'd6: r = (ua < ub) ? ua : ub;
      default: r = (ua > ub) ? ua : ub;
    endcase
    res = old;
    case (sz)
      2'd0: res[lo +: 8]  = r[7:0];
      2'd1: res[lo +: 16] = r[15:0];
      2'd2: res[lo +: 32] = r[31:0];
      default: res = r;
    endcase
    return res;
  endfunction

  function automatic logic [63:0] merge(logic [63:0] o, logic [63:0] d, logic [7:0] m);
    for (int b = 0; b < 8; b++) if (m[b]) o[8*b +: 8] = d[8*b +: 8];
    return o;
  endfunction

  task automatic push(logic [2:0] k, logic [3:0] cx, logic [1:0] bt, logic [63:0] d, bit hd, string tg);
    q_kind.push_back(k); q_cx.push_back(cx); q_beat.push_back(bt);
    q_data.push_back(d); q_hd.push_back(hd); q_tag.push_back(tg);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) rmem[i] = '0;
      mph = 0;
      prev_stall = 0;
    end else begin
      prev_stall = (mph == 2) && !gnt_ready;
      case (mph)
        0: if (acq_valid) begin
          mph = 2;
          case (acq_kind)
            3'b000: push(3'b100, acq_cxid, acq_beat, rmem[{acq_block, acq_beat}], 1, cur_tag);
            3'b001: for (int b = 0; b < 4; b++)
                      push(3'b101, acq_cxid, 2'(b), rmem[{acq_block, 2'(b)}], 1, cur_tag);
            3'b010: begin
              rmem[{acq_block, acq_beat}] = merge(rmem[{acq_block, acq_beat}], acq_data, acq_mask);
              push(3'b011, acq_cxid, 0, 0, 0, "R5");
            end
            3'b011: begin
              rmem[{acq_block, 2'd0}] = merge(rmem[{acq_block, 2'd0}], acq_data, acq_mask);
              bblk = acq_block; bcnt = 1; mph = 1;
              push(3'b011, acq_cxid, 0, 0, 0, "R5");
            end
            3'b100: begin
              push(3'b100, acq_cxid, acq_beat, rmem[{acq_block, acq_beat}], 1, "R7");
              rmem[{acq_block, acq_beat}] = ref_amo(rmem[{acq_block, acq_beat}], acq_data,
                                                    acq_amo_op, acq_amo_size, acq_amo_byte);
            end
            default: push(3'b001, acq_cxid, 0, 0, 0, "R11");
          endcase
        end
        1: if (acq_valid) begin
          rmem[{bblk, 2'(bcnt)}] = merge(rmem[{bblk, 2'(bcnt)}], acq_data, acq_mask);
          if (bcnt == 3) mph = 2; else bcnt++;
        end
        2: if (gnt_ready) begin
          void'(q_kind.pop_front()); void'(q_cx.pop_front()); void'(q_beat.pop_front());
          void'(q_data.pop_front()); void'(q_hd.pop_front()); void'(q_tag.pop_front());
          if (q_kind.size() == 0) mph = 3;
        end
        default: if (fin_valid && fin_mxid == 1'b0) mph = 0;
      endcase
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8", "acq_ready", 64'(acq_ready), 64'(mph <= 1));
      chk("R8", "fin_ready", 64'(fin_ready), 64'(mph == 3));
      chk("R8", "gnt_valid", 64'(gnt_valid), 64'(mph == 2));
      if (mph == 2 && q_kind.size() > 0) begin
        chk("R2", "gnt_kind", 64'(gnt_kind), 64'(q_kind[0]));
        chk("R2", "gnt_cxid", 64'(gnt_cxid), 64'(q_cx[0]));
        chk("R2", "gnt_mxid", 64'(gnt_mxid), 64'd0);
        if (q_hd[0]) begin
          chk(q_tag[0] == "R3" ? "R3" : q_tag[0], "gnt_beat", 64'(gnt_beat), 64'(q_beat[0]));
          chk(prev_stall ? "R10" : q_tag[0], "gnt_data", gnt_data, q_data[0]);
        end
      end
    end
  end

  always @(negedge clk) gnt_ready = !bp || (cyc % 3 == 0);

  task automatic txn(logic [2:0] k, logic [3:0] cx, logic [3:0] blk, logic [1:0] bt,
                     logic [63:0] d, logic [7:0] m, logic [2:0] op, logic [1:0] sz,
                     logic [2:0] bo, bit bad_fin);
    @(negedge clk);
    acq_valid = 1; acq_kind = k; acq_cxid = cx; acq_block = blk; acq_beat = bt;
    acq_data = (k == 3'b011) ? bp_data[0] : d;
    acq_mask = (k == 3'b011) ? bp_mask[0] : m;
    acq_amo_op = op; acq_amo_size = sz; acq_amo_byte = bo;
    @(posedge clk);
    if (k == 3'b011) begin
      for (int b = 1; b < 4; b++) begin
        @(negedge clk);
        acq_data = bp_data[b]; acq_mask = bp_mask[b]; acq_beat = 2'(3 - b);
        acq_kind = 3'b110;
        @(posedge clk);
      end
    end
    @(negedge clk);
    acq_valid = 0;
    while (mph != 3) @(negedge clk);
    fin_valid = 1;
    fin_mxid = bad_fin ? 1'b1 : 1'b0;
    @(posedge clk);
    if (bad_fin) begin
      @(negedge clk);
      chk("R9", "acq_ready after bad finish", 64'(acq_ready), 64'd0);
      chk("R9", "fin_ready after bad finish", 64'(fin_ready), 64'd1);
      fin_mxid = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    fin_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    finish_up();
  end

  initial begin
    logic [63:0] base, src;
    repeat (2) @(negedge clk);
    chk("R1", "acq_ready in reset", 64'(acq_ready), 64'd1);
    chk("R1", "gnt_valid in reset", 64'(gnt_valid), 64'd0);
    chk("R1", "fin_ready in reset", 64'(fin_ready), 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1;

    cur_tag = "R1";
    txn(3'b001, 4'h1, 4'd5, 0, 0, 0, 0, 0, 0, 0);
    txn(3'b000, 4'h2, 4'd12, 2'd3, 0, 0, 0, 0, 0, 0);

    txn(3'b010, 4'h3, 4'd3, 2'd1, 64'h1122334455667788, 8'hFF, 0, 0, 0, 0);
    txn(3'b010, 4'h4, 4'd3, 2'd1, 64'hAAAAAAAAAAAAAAAA, 8'h0F, 0, 0, 0, 0);
    txn(3'b010, 4'h5, 4'd3, 2'd1, 64'h5555555555555555, 8'h00, 0, 0, 0, 0);
    cur_tag = "R5";
    txn(3'b000, 4'h6, 4'd3, 2'd1, 0, 0, 0, 0, 0, 0);

    bp_data[0] = 64'h0123456789ABCDEF; bp_mask[0] = 8'hFF;
    bp_data[1] = 64'hFEDCBA9876543210; bp_mask[1] = 8'hF0;
    bp_data[2] = 64'hCAFEF00DDEADBEEF; bp_mask[2] = 8'h0F;
    bp_data[3] = 64'h0F1E2D3C4B5A6978; bp_mask[3] = 8'h3C;
    txn(3'b011, 4'h7, 4'd7, 2'd2, 0, 0, 0, 0, 0, 0);
    cur_tag = "R4";
    txn(3'b001, 4'h8, 4'd7, 2'd1, 0, 0, 0, 0, 0, 0);
    cur_tag = "R3";
    txn(3'b000, 4'h9, 4'd7, 2'd2, 0, 0, 0, 0, 0, 0);
    txn(3'b000, 4'hA, 4'd7, 2'd0, 0, 0, 0, 0, 0, 0);

    bp = 1;
    cur_tag = "R10";
    txn(3'b001, 4'hB, 4'd7, 0, 0, 0, 0, 0, 0, 0);
    txn(3'b000, 4'hC, 4'd3, 2'd1, 0, 0, 0, 0, 0, 0);
    bp = 0;

    txn(3'b010, 4'hD, 4'd9, 2'd0, 64'h80FF7F01FFFF0001, 8'hFF, 0, 0, 0, 0);
    base = 64'hF07F800100FF7E81;
    cur_tag = "R6";
    for (int op = 0; op < 8; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        int sh;
        sh  = op * 8 + sz * 3;
        src = (base << sh) | (base >> (64 - sh));
        txn(3'b100, 4'(op + sz), 4'd9, 2'd0, src, 0, 3'(op), 2'(sz), 3'((op * 3 + sz * 5) % 8), 0);
        txn(3'b000, 4'hE, 4'd9, 2'd0, 0, 0, 0, 0, 0, 0);
      end
    end

    txn(3'b100, 4'h1, 4'd10, 2'd2, 64'h00000000000000FF, 0, 3'd4, 2'd0, 3'd0, 0);
    txn(3'b100, 4'h2, 4'd10, 2'd2, 64'h0000000000000001, 0, 3'd5, 2'd0, 3'd0, 0);
    txn(3'b000, 4'h3, 4'd10, 2'd2, 0, 0, 0, 0, 0, 0);

    txn(3'b101, 4'h4, 4'd7, 0, 64'hFFFFFFFFFFFFFFFF, 8'hFF, 0, 0, 0, 0);
    cur_tag = "R11";
    txn(3'b001, 4'h5, 4'd7, 0, 0, 0, 0, 0, 0, 0);

    cur_tag = "R3";
    txn(3'b000, 4'h6, 4'd9, 2'd0, 0, 0, 0, 0, 0, 1);
    txn(3'b000, 4'h7, 4'd3, 2'd1, 0, 0, 0, 0, 0, 0);

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule